// File: doc/BRIEF.md
# Device Interrupt Routing Controller

This block collects interrupt requests from a small fixed group of on-chip sources and turns each accepted request into a delivery event. The event names a target processor and an interrupt vector. Each source has two registers. A routing register selects the processor and the vector. A control register holds a mask flag and a pending flag. When the block accepts a request, it sets both flags. The source therefore stays silent until software clears its mask again, and software clears the pending flag with a dedicated write-one bit.

Software can also raise an inter-processor interrupt by writing a dispatch window. The write carries a command type, a target processor and a vector. Only the interrupt command produces an event. Reset, idle and resume commands are accepted and discarded.

All events leave the block on one registered strobe that carries the processor number and the vector. When a source event and a dispatch event arrive in the same cycle, the dispatch waits in a one-entry holding slot and is posted in the next cycle, so no event is lost.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every source is masked, no source is pending, every routing field is zero, and `post_valid` and `reg_err` are low.
- R2: The routing register of source i sits at byte offset 8*i from 0x000. Bits 12:8 hold the target CPU and bits 5:0 hold the vector. All other bits are not stored and read as zero.
- R3: The control register of source i sits at byte offset 0x400 + 8*i. A read returns the mask in bit 2 and the pending flag in bit 0. A write loads the mask from bit 2. Writing 1 to bit 1 clears pending; writing 0 to bit 1 leaves pending unchanged.
- R4: While a source is masked, its request is dropped: no event is posted and its pending flag is not set.
- R5: A request from an unmasked source produces a `post_valid` pulse in the following cycle, carrying that source's routed CPU and vector. The same request sets the source's mask and pending flags, so a later request from that source is dropped until software clears the mask.
- R6: Requests are level-sensitive. When several unmasked sources request together, one source is accepted per cycle, lowest index first.
- R7: A write anywhere in 0x800..0x8FF with a type of 0 in bits 17:16 posts an event in the following cycle. The event takes its CPU from bits 12:8 and its vector from bits 5:0.
- R8: A dispatch write with type 1, 2 or 3 posts no event.
- R9: If a source is accepted in the same cycle as a type-0 dispatch write, the source event is posted first and the dispatch event in the next cycle.
- R10: An access to any other offset reads zero and has no effect on write. In the cycle after the access, `reg_err` pulses high for one cycle.
- R11: Read data appears on `reg_rdata` in the cycle after the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 4 | Level interrupt request, one bit per source |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after a read |
| reg_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| post_valid | output | 1 | Delivery event strobe |
| post_cpu | output | 5 | Target CPU of the event |
| post_vec | output | 6 | Vector of the event |

## Verification
Acceptance of a source request and a type-0 dispatch write can land in the same clock edge. In that case both compete for the single delivery strobe. The bench provokes the collision by raising an unmasked source request and presenting the dispatch write during the same cycle. It queues the source's routed event ahead of the dispatch event. The scoreboard then requires two events on consecutive cycles, in exactly that order, with no third event.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Address regions recognised by the register decoder
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_ROUTE = 2'd1,
    RGN_CTRL  = 2'd2,
    RGN_IPI   = 2'd3
  } rgn_e;

  // Dispatch command codes (bits 17:16 of a dispatch write)
  typedef enum logic [1:0] {
    IPI_INTR   = 2'd0,
    IPI_RESET  = 2'd1,
    IPI_IDLE   = 2'd2,
    IPI_RESUME = 2'd3
  } ipi_type_e;

  localparam int unsigned ROUTE_BASE  = 32'h000;
  localparam int unsigned CTRL_BASE   = 32'h400;
  localparam int unsigned IPI_BASE    = 32'h800;
  localparam int unsigned IPI_SPAN    = 32'h100;
  localparam int unsigned STRIDE_LG2  = 3;

  // Field positions shared by decode, bank and read mux
  localparam int unsigned CPU_LSB     = 8;
  localparam int unsigned VEC_LSB     = 0;
  localparam int unsigned TYPE_LSB    = 16;
  localparam int unsigned MASK_BIT    = 2;
  localparam int unsigned CLR_BIT     = 1;
  localparam int unsigned PEND_BIT    = 0;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_route_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(NUM_SRC << STRIDE_LG2);
  localparam logic [ADDR_W-1:0] R_BASE    = ADDR_W'(ROUTE_BASE);
  localparam logic [ADDR_W-1:0] C_BASE    = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] D_BASE    = ADDR_W'(IPI_BASE);
  localparam logic [ADDR_W-1:0] D_SPAN    = ADDR_W'(IPI_SPAN);

  logic [ADDR_W-1:0] off_route;
  logic [ADDR_W-1:0] off_ctrl;
  logic [ADDR_W-1:0] off_ipi;

  always_comb begin
    off_route = addr - R_BASE;
    off_ctrl  = addr - C_BASE;
    off_ipi   = addr - D_BASE;
    rgn       = RGN_NONE;
    idx       = '0;
    if (off_route < BANK_SPAN) begin
      rgn = RGN_ROUTE;
      idx = off_route[STRIDE_LG2 +: IDX_W];
    end else if (off_ctrl < BANK_SPAN) begin
      rgn = RGN_CTRL;
      idx = off_ctrl[STRIDE_LG2 +: IDX_W];
    end else if (off_ipi < D_SPAN) begin
      rgn = RGN_IPI;
    end
  end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            route_we,
  input  logic                            ctrl_we,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [CPU_W-1:0]                wr_cpu,
  input  logic [VEC_W-1:0]                wr_vec,
  input  logic                            wr_mask,
  input  logic                            wr_clr,
  input  logic [NUM_SRC-1:0]              accept,
  output logic [NUM_SRC-1:0]              mask_q,
  output logic [NUM_SRC-1:0]              pend_q,
  output logic [NUM_SRC-1:0][CPU_W-1:0]   route_cpu,
  output logic [NUM_SRC-1:0][VEC_W-1:0]   route_vec
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic             sel;
    logic             route_en;
    logic             ctrl_en;
    logic             mask_n;
    logic             pend_n;
    logic [CPU_W-1:0] cpu_q;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
      sel      = (wr_idx == IDX_W'(g));
      route_en = route_we && sel;
      ctrl_en  = (ctrl_we && sel) || accept[g];
      // Software write to the mask wins; acceptance re-masks otherwise
      if (ctrl_we && sel) mask_n = wr_mask;
      else                mask_n = 1'b1;
      // Acceptance sets pending; write-one-to-clear otherwise
      if (accept[g])                    pend_n = 1'b1;
      else if (ctrl_we && sel && wr_clr) pend_n = 1'b0;
      else                              pend_n = pend_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cpu_q     <= '0;
        vec_q     <= '0;
        mask_q[g] <= 1'b1;
        pend_q[g] <= 1'b0;
      end else begin
        if (route_en) begin
          cpu_q <= wr_cpu;
          vec_q <= wr_vec;
        end
        if (ctrl_en) begin
          mask_q[g] <= mask_n;
          pend_q[g] <= pend_n;
        end
      end
    end

    assign route_cpu[g] = cpu_q;
    assign route_vec[g] = vec_q;
  end

endmodule

// File: rtl/irq_post_arb.sv
module irq_post_arb #(
  parameter int NUM_SRC = 4,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             req,
  input  logic [NUM_SRC-1:0][CPU_W-1:0]  route_cpu,
  input  logic [NUM_SRC-1:0][VEC_W-1:0]  route_vec,
  input  logic                           ipi_fire,
  input  logic [CPU_W-1:0]               ipi_cpu,
  input  logic [VEC_W-1:0]               ipi_vec,
  output logic [NUM_SRC-1:0]             accept,
  output logic                           hold_vld,
  output logic                           post_valid,
  output logic [CPU_W-1:0]               post_cpu,
  output logic [VEC_W-1:0]               post_vec
);

  logic             found;
  logic [CPU_W-1:0] src_cpu;
  logic [VEC_W-1:0] src_vec;
  logic             post_vld_n;
  logic [CPU_W-1:0] post_cpu_n;
  logic [VEC_W-1:0] post_vec_n;
  logic             hold_vld_n;
  logic [CPU_W-1:0] hold_cpu_q;
  logic [VEC_W-1:0] hold_vec_q;
  logic             hold_vld_q;
  logic             post_vld_q;
  logic [CPU_W-1:0] post_cpu_q;
  logic [VEC_W-1:0] post_vec_q;

  // Fixed priority, lowest index first; a held dispatch blocks sources
  always_comb begin
    accept  = '0;
    found   = 1'b0;
    src_cpu = '0;
    src_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!found && req[i] && !hold_vld_q) begin
        accept[i] = 1'b1;
        found     = 1'b1;
        src_cpu   = route_cpu[i];
        src_vec   = route_vec[i];
      end
    end
  end

  always_comb begin
    post_vld_n = 1'b1;
    post_cpu_n = ipi_cpu;
    post_vec_n = ipi_vec;
    if (hold_vld_q) begin
      post_cpu_n = hold_cpu_q;
      post_vec_n = hold_vec_q;
    end else if (found) begin
      post_cpu_n = src_cpu;
      post_vec_n = src_vec;
    end else if (!ipi_fire) begin
      post_vld_n = 1'b0;
    end
    hold_vld_n = ipi_fire && (hold_vld_q || found);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_cpu_q <= '0;
      hold_vec_q <= '0;
      post_vld_q <= 1'b0;
      post_cpu_q <= '0;
      post_vec_q <= '0;
    end else begin
      hold_vld_q <= hold_vld_n;
      post_vld_q <= post_vld_n;
      if (ipi_fire) begin
        hold_cpu_q <= ipi_cpu;
        hold_vec_q <= ipi_vec;
      end
      if (post_vld_n) begin
        post_cpu_q <= post_cpu_n;
        post_vec_q <= post_vec_n;
      end
    end
  end

  assign hold_vld   = hold_vld_q;
  assign post_valid = post_vld_q;
  assign post_cpu   = post_cpu_q;
  assign post_vec   = post_vec_q;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_err,
  output logic               post_valid,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  rgn_e                          rgn;
  logic [IDX_W-1:0]              idx;
  logic                          wr_acc;
  logic                          rd_acc;
  logic                          route_we;
  logic                          ctrl_we;
  logic                          ipi_fire;
  logic [NUM_SRC-1:0]            src_mask;
  logic [NUM_SRC-1:0]            src_pend;
  logic [NUM_SRC-1:0][CPU_W-1:0] route_cpu;
  logic [NUM_SRC-1:0][VEC_W-1:0] route_vec;
  logic [NUM_SRC-1:0]            req;
  logic [NUM_SRC-1:0]            accept;
  logic                          hold_vld;
  logic [DATA_W-1:0]             rdata_n;
  logic                          err_n;
  logic [DATA_W-1:0]             rdata_q;
  logic                          err_q;

  irq_reg_decode #(
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC),
    .IDX_W  (IDX_W)
  ) dec_i (
    .addr(reg_addr),
    .rgn (rgn),
    .idx (idx)
  );

  always_comb begin
    wr_acc   = reg_valid && reg_write;
    rd_acc   = reg_valid && !reg_write;
    route_we = wr_acc && (rgn == RGN_ROUTE);
    ctrl_we  = wr_acc && (rgn == RGN_CTRL);
    ipi_fire = wr_acc && (rgn == RGN_IPI) &&
               (reg_wdata[TYPE_LSB +: 2] == 2'(IPI_INTR));
    req      = src_irq & ~src_mask;
  end

  irq_src_bank #(
    .NUM_SRC(NUM_SRC),
    .CPU_W  (CPU_W),
    .VEC_W  (VEC_W),
    .IDX_W  (IDX_W)
  ) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .route_we (route_we),
    .ctrl_we  (ctrl_we),
    .wr_idx   (idx),
    .wr_cpu   (reg_wdata[CPU_LSB +: CPU_W]),
    .wr_vec   (reg_wdata[VEC_LSB +: VEC_W]),
    .wr_mask  (reg_wdata[MASK_BIT]),
    .wr_clr   (reg_wdata[CLR_BIT]),
    .accept   (accept),
    .mask_q   (src_mask),
    .pend_q   (src_pend),
    .route_cpu(route_cpu),
    .route_vec(route_vec)
  );

  irq_post_arb #(
    .NUM_SRC(NUM_SRC),
    .CPU_W  (CPU_W),
    .VEC_W  (VEC_W)
  ) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .route_cpu (route_cpu),
    .route_vec (route_vec),
    .ipi_fire  (ipi_fire),
    .ipi_cpu   (reg_wdata[CPU_LSB +: CPU_W]),
    .ipi_vec   (reg_wdata[VEC_LSB +: VEC_W]),
    .accept    (accept),
    .hold_vld  (hold_vld),
    .post_valid(post_valid),
    .post_cpu  (post_cpu),
    .post_vec  (post_vec)
  );

  // Read mux and error detection
  always_comb begin
    rdata_n = '0;
    case (rgn)
      RGN_ROUTE: begin
        rdata_n[CPU_LSB +: CPU_W] = route_cpu[idx];
        rdata_n[VEC_LSB +: VEC_W] = route_vec[idx];
      end
      RGN_CTRL: begin
        rdata_n[MASK_BIT] = src_mask[idx];
        rdata_n[PEND_BIT] = src_pend[idx];
      end
      default: rdata_n = '0;
    endcase
    err_n = reg_valid && (rgn == RGN_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_n;
      if (rd_acc) rdata_q <= rdata_n;
    end
  end

  assign reg_rdata = rdata_q;
  assign reg_err   = err_q;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_valid,
  input logic               reg_write,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               reg_err,
  input logic               post_valid,
  input logic [NUM_SRC-1:0] accept,
  input logic [NUM_SRC-1:0] src_mask,
  input logic               hold_vld,
  input logic               ipi_fire
);

  logic ign_dispatch;
  assign ign_dispatch = reg_valid && reg_write &&
                        (reg_addr >= ADDR_W'(12'h800)) && (reg_addr < ADDR_W'(12'h900)) &&
                        (reg_wdata[17:16] != 2'd0);

  p_masked_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept & src_mask) == '0);

  p_accept_rearms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept != '0) |=> ((src_mask & $past(accept)) == $past(accept)));

  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept));

  p_post_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> $past((accept != '0) || hold_vld || ipi_fire));

  p_type_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_dispatch && (accept == '0) && !hold_vld) |=> !post_valid);

  p_err_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(reg_valid));

endmodule

bind irq_route_ctrl irq_route_chk #(
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_err   (reg_err),
  .post_valid(post_valid),
  .accept    (accept),
  .src_mask  (src_mask),
  .hold_vld  (hold_vld),
  .ipi_fire  (ipi_fire)
);

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_irq = '0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        post_valid;
  logic [4:0]  post_cpu;
  logic [5:0]  post_vec;

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_route_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
  );

  function automatic logic [4:0] rcpu(int i); return 5'(3 + 7*i);  endfunction
  function automatic logic [5:0] rvec(int i); return 6'(10 + 11*i); endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_post(logic [4:0] c, logic [5:0] v, string tag);
    exp_q.push_back({c, v});
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && post_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R8 unexpected event: actual 0x%0h expected none", {post_cpu, post_vec});
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({post_cpu, post_vec} !== e) begin
          errors++;
          $display("FAIL %s event: actual 0x%0h expected 0x%0h", t, {post_cpu, post_vec}, e);
        end
      end
    end
  end

  // One access; returns after the edge that registers it
  task automatic access(bit wr, logic [11:0] a, logic [31:0] d);
    reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd_check(logic [11:0] a, logic [31:0] exp, string tag);
    access(1'b0, a, '0);
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic drained(string tag);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic pulse_src(logic [3:0] m, int cyc);
    src_irq = m;
    repeat (cyc) @(negedge clk);
    src_irq = '0;
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(post_valid === 1'b0 && reg_err === 1'b0, "R1 outputs idle", {post_valid, reg_err}, 0);
    rd_check(12'h000, 32'h0, "R1 route0 zero");
    rd_check(12'h018, 32'h0, "R1 route3 zero");
    rd_check(12'h400, 32'h4, "R1 ctrl0 masked");
    rd_check(12'h418, 32'h4, "R1 ctrl3 masked");

    // R2 routing registers with junk in unstored bits
    for (int i = 0; i < 4; i++)
      access(1'b1, 12'(8*i), 32'hFFFF_E0C0 | (32'(rcpu(i)) << 8) | 32'(rvec(i)));
    for (int i = 0; i < 4; i++)
      rd_check(12'(8*i), (32'(rcpu(i)) << 8) | 32'(rvec(i)), "R2 route readback R11");

    // R4 masked source drops
    pulse_src(4'b0100, 2);
    drained("R4 masked no event");
    rd_check(12'h410, 32'h4, "R4 no pending");

    // R3/R5 unmask, fire, one-shot
    access(1'b1, 12'h410, 32'h0);
    rd_check(12'h410, 32'h0, "R3 mask cleared");
    expect_post(rcpu(2), rvec(2), "R5 src2");
    pulse_src(4'b0100, 1);
    drained("R5 src2 posted");
    rd_check(12'h410, 32'h5, "R5 mask and pend set");
    pulse_src(4'b0100, 1);
    drained("R5 re-masked drops");
    access(1'b1, 12'h410, 32'h4);
    rd_check(12'h410, 32'h5, "R3 clear bit zero keeps pend");
    access(1'b1, 12'h410, 32'h2);
    rd_check(12'h410, 32'h0, "R3 clear bit one clears pend");

    // R6 simultaneous sources, lowest first
    access(1'b1, 12'h400, 32'h0);
    access(1'b1, 12'h408, 32'h0);
    expect_post(rcpu(0), rvec(0), "R6 first src0");
    expect_post(rcpu(1), rvec(1), "R6 second src1");
    pulse_src(4'b0011, 3);
    drained("R6 both posted");
    rd_check(12'h400, 32'h5, "R6 src0 state");
    rd_check(12'h408, 32'h5, "R6 src1 state");

    // R7 dispatch type 0
    expect_post(5'd17, 6'd42, "R7 dispatch base");
    access(1'b1, 12'h800, (32'd17 << 8) | 32'd42);
    expect_post(5'd31, 6'd63, "R7 dispatch top");
    access(1'b1, 12'h8F8, 32'hFFFC_FFFF);
    drained("R7 dispatches posted");

    // R8 other types ignored
    access(1'b1, 12'h800, (32'd1 << 16) | (32'd5 << 8) | 32'd6);
    access(1'b1, 12'h808, (32'd2 << 16) | (32'd5 << 8) | 32'd6);
    access(1'b1, 12'h810, (32'd3 << 16) | (32'd5 << 8) | 32'd6);
    drained("R8 no events");

    // R9 collision: source first, dispatch next cycle
    access(1'b1, 12'h418, 32'h0);
    expect_post(rcpu(3), rvec(3), "R9 source first");
    expect_post(5'd9, 6'd7, "R9 dispatch second");
    src_irq = 4'b1000;
    access(1'b1, 12'h840, (32'd9 << 8) | 32'd7);
    src_irq = '0;
    check(post_valid === 1'b1 && post_cpu === rcpu(3), "R9 source at first edge", post_cpu, rcpu(3));
    @(negedge clk);
    check(post_valid === 1'b1 && post_cpu === 5'd9, "R9 dispatch at next edge", post_cpu, 9);
    drained("R9 exactly two events");

    // R10 unmapped offsets
    access(1'b0, 12'h000, '0);
    rd_check(12'h200, 32'h0, "R10 unmapped reads zero");
    check(reg_err === 1'b1, "R10 err on read", reg_err, 1);
    @(negedge clk);
    check(reg_err === 1'b0, "R10 err one cycle", reg_err, 0);
    access(1'b1, 12'h020, 32'h0000_1F3F);
    check(reg_err === 1'b1, "R10 err on write", reg_err, 1);
    access(1'b1, 12'h420, 32'h0);
    rd_check(12'h000, (32'(rcpu(0)) << 8) | 32'(rvec(0)), "R10 write ignored route");
    rd_check(12'h418, 32'h5, "R10 write ignored ctrl");
    check(reg_err === 1'b0, "R10 no err mapped", reg_err, 0);
    drained("R10 no events");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule